// File: doc/BRIEF.md
# Mode Control Register with Falling-Edge Interrupt Latches

This block is a single 8-bit control and status register on a simple processor bus. The bus has an address, a write strobe, write data and combinational read data. Four bits are configuration bits that software owns, and each drives a select or enable line to neighbouring logic:

- the sync source used by the display data channel,
- the source that the timing measurement logic analyses,
- the enable for the divided horizontal sync output pin,
- the external clock speed mode.

Two further bits are sticky latches. Each one records a falling edge on one of two external pins, A and B. Each pin has its own interrupt enable bit. A latch, its enable and a global interrupt mask input together form a per-pin interrupt request. A combined request is also provided.

Each pin goes through a synchroniser before edge detection, so the pins may be fully asynchronous. Software clears a latch by writing 0 to its bit. Writing 1 to a latch bit leaves it as it is, so a read-modify-write of the configuration bits cannot lose a pending edge. A hardware edge that arrives in the same cycle as a software clear wins.

The bus has no back-pressure. A write completes in the cycle its strobe is sampled, and a read is valid in the same cycle its address is presented.

Top module: `edge_irq_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x10. `fast_mode` is 1, all other select outputs are 0, and all interrupt outputs are 0.
- R2: The register responds only at bus address 0x09. A read at any other address returns 0x00. A write at any other address changes nothing.
- R3: A write at 0x09 stores data bits 7..4 directly. Bit 7 drives `sync_sel` (0 selects the primary sync input for the data channel, 1 selects the secondary one). Bit 6 drives `fly_sel` (0 selects sync outputs, 1 selects flyback inputs). Bit 5 drives `hdiv_en`. Bit 4 drives `fast_mode` (0 means 12 MHz, 1 means 24 MHz).
- R4: A write at 0x09 stores data bit 0 as the pin A interrupt enable and data bit 1 as the pin B interrupt enable. Both read back at those positions.
- R5: A falling edge on `pin_a` sets bit 2, and a falling edge on `pin_b` sets bit 3. The bit reads 1 from the third rising clock edge after the pin change. A rising edge sets nothing.
- R6: Writing 0 to bit 2 or bit 3 clears that latch. Writing 1 leaves the latch unchanged, so a latch that is 0 stays 0.
- R7: If a detected falling edge and a clearing write to the same latch fall on the same clock edge, the latch ends up set.
- R8: `irq_a` is 1 exactly when bit 2 is 1, bit 0 is 1 and `irq_mask` is 0. `irq_b` is 1 exactly when bit 3 is 1, bit 1 is 1 and `irq_mask` is 0.
- R9: `irq` is the OR of `irq_a` and `irq_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; register value when the address matches, else 0 |
| pin_a | input | 1 | External pin A, asynchronous, idle high |
| pin_b | input | 1 | External pin B, asynchronous, idle high |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks all requests |
| sync_sel | output | 1 | Data-channel sync source select |
| fly_sel | output | 1 | Timing measurement source select |
| hdiv_en | output | 1 | Divided horizontal sync output enable |
| fast_mode | output | 1 | External clock speed mode |
| irq_a | output | 1 | Pin A interrupt request |
| irq_b | output | 1 | Pin B interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
A synchronised falling edge on pin A and a software write that clears latch A can meet on the same clock edge. The bench provokes this by dropping `pin_a`, counting two rising edges so that the detected edge is pending, and then presenting a write of 0x00 for the following edge. The result is judged by reading back the register: bit 2 must still be 1. In a separate step, a clearing write with no edge pending must drop the bit.

// File: rtl/eir_pkg.sv
package eir_pkg;
  localparam int REG_W       = 8;
  localparam int NPIN        = 2;
  localparam int CFG_W       = 4;
  // bit positions the neighbouring logic and software rely on
  localparam int B_SYNC_SEL  = 7;
  localparam int B_FLY_SEL   = 6;
  localparam int B_HDIV_EN   = 5;
  localparam int B_FAST      = 4;
  localparam int B_CFG_LSB   = 4;
  localparam int B_LATCH_LSB = 2;
  localparam int B_EN_LSB    = 0;
endpackage

// File: rtl/eir_pin_sync.sv
module eir_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/eir_edge_latch.sv
module eir_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_val_i,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic clr;
  assign clr = wr_i & ~wbit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= rst_val_i;
    else        q_o <= set_i | (q_o & ~clr);  // set wins over clear
  end
endmodule

// File: rtl/edge_irq_ctrl_reg.sv
module edge_irq_ctrl_reg
  import eir_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h09,
  parameter logic [7:0]        RESET_VAL   = 8'h10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              irq_mask,
  output logic              sync_sel,
  output logic              fly_sel,
  output logic              hdiv_en,
  output logic              fast_mode,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq
);
  logic             hit, wr_hit;
  logic [CFG_W-1:0] cfg_q;
  logic [NPIN-1:0]  en_q, lat_q, fall, pins, irq_vec;
  logic [REG_W-1:0] reg_q;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_wr & hit;
  assign pins   = {pin_b, pin_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RESET_VAL[B_CFG_LSB +: CFG_W];
      en_q  <= RESET_VAL[B_EN_LSB +: NPIN];
    end else if (wr_hit) begin
      cfg_q <= bus_wdata[B_CFG_LSB +: CFG_W];
      en_q  <= bus_wdata[B_EN_LSB +: NPIN];
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    eir_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins[i]),
      .fall_o (fall[i])
    );
    eir_edge_latch u_lat (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_val_i (RESET_VAL[B_LATCH_LSB + i]),
      .set_i     (fall[i]),
      .wr_i      (wr_hit),
      .wbit_i    (bus_wdata[B_LATCH_LSB + i]),
      .q_o       (lat_q[i])
    );
    assign irq_vec[i] = lat_q[i] & en_q[i] & ~irq_mask;
  end

  always_comb begin
    reg_q = '0;
    reg_q[B_CFG_LSB   +: CFG_W] = cfg_q;
    reg_q[B_LATCH_LSB +: NPIN]  = lat_q;
    reg_q[B_EN_LSB    +: NPIN]  = en_q;
  end

  assign bus_rdata = hit ? reg_q : '0;
  assign sync_sel  = reg_q[B_SYNC_SEL];
  assign fly_sel   = reg_q[B_FLY_SEL];
  assign hdiv_en   = reg_q[B_HDIV_EN];
  assign fast_mode = reg_q[B_FAST];
  assign irq_a     = irq_vec[0];
  assign irq_b     = irq_vec[1];
  assign irq       = |irq_vec;
endmodule

// File: rtl/eir_checker.sv
module eir_checker #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h09
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        reg_q,
  input logic              irq_mask,
  input logic              irq_a,
  input logic              irq_b,
  input logic              irq
);
  logic wr_hit;
  assign wr_hit = bus_wr && (bus_addr == REG_ADDR);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R8
  AST_IRQ_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (reg_q[2] && reg_q[0])); // R8
  AST_IRQ_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> (reg_q[3] && reg_q[1])); // R8
  AST_IRQ_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a || irq_b) |-> irq); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(reg_q[7:4])); // R3
  AST_LATCH_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[2] && !(wr_hit && !bus_wdata[2])) |=> reg_q[2]); // R6
  AST_LATCH_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[3] && !(wr_hit && !bus_wdata[3])) |=> reg_q[3]); // R6
endmodule

bind edge_irq_ctrl_reg eir_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .reg_q     (reg_q),
  .irq_mask  (irq_mask),
  .irq_a     (irq_a),
  .irq_b     (irq_b),
  .irq       (irq)
);

// File: tb/edge_irq_ctrl_reg_tb.sv
module edge_irq_ctrl_reg_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] ADR = 8'h09;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = ADR;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pin_a = 1'b1, pin_b = 1'b1, irq_mask = 1'b0;
  logic       sync_sel, fly_sel, hdiv_en, fast_mode, irq_a, irq_b, irq;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  edge_irq_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_a(pin_a), .pin_b(pin_b),
    .irq_mask(irq_mask), .sync_sel(sync_sel), .fly_sel(fly_sel),
    .hdiv_en(hdiv_en), .fast_mode(fast_mode), .irq_a(irq_a), .irq_b(irq_b),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = ADR;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = ADR;
  endtask

  task automatic fall_pin(input int which);
    @(negedge clk);
    if (which == 0) pin_a = 1'b0; else pin_b = 1'b0;
    repeat (4) @(negedge clk);
    if (which == 0) pin_a = 1'b1; else pin_b = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(ADR, r);
    chk("R1 reset value", r, 8'h10);
    chk("R1 reset outputs", {sync_sel, fly_sel, hdiv_en, fast_mode, 1'b0, irq_a, irq_b, irq}, 8'h10);

    // R2 other addresses
    rd(8'h0A, r);
    chk("R2 foreign read", r, 8'h00);
    wr(8'h0A, 8'hEF);
    wr(8'h08, 8'h00);
    rd(ADR, r);
    chk("R2 foreign write ignored", r, 8'h10);

    // R3 R4 exhaustive write sweep, latches stay 0
    for (int v = 0; v < 256; v++) begin
      wr(ADR, 8'(v));
      rd(ADR, r);
      chk("R3/R4 readback", r, 8'(v) & 8'hF3);
      chk("R3 select outputs", {4'h0, sync_sel, fly_sel, hdiv_en, fast_mode}, 8'(v >> 4));
    end

    // R5 falling edge timing on pin A
    wr(ADR, 8'h00);
    @(negedge clk); pin_a = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd(ADR, r);
    chk("R5 A not yet set after two edges", r, 8'h00);
    @(negedge clk); rd(ADR, r);
    chk("R5 A set at third edge", r, 8'h04);
    pin_a = 1'b1;
    repeat (5) @(negedge clk);
    rd(ADR, r);
    chk("R5 rising edge sets nothing", r, 8'h04);
    fall_pin(1);
    rd(ADR, r);
    chk("R5 B set", r, 8'h0C);

    // R6 write-one keeps, write-zero clears
    wr(ADR, 8'hFF);
    rd(ADR, r);
    chk("R6 write one keeps latches", r, 8'hFF);
    wr(ADR, 8'hF7);
    rd(ADR, r);
    chk("R6 clear B only", r, 8'hF7);
    wr(ADR, 8'hF3);
    rd(ADR, r);
    chk("R6 clear A", r, 8'hF3);

    // R7 edge and clear on the same clock edge
    wr(ADR, 8'h00);
    @(negedge clk); pin_a = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_addr = ADR; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(ADR, r);
    chk("R7 set wins over clear", r, 8'h04);
    pin_a = 1'b1;
    repeat (4) @(negedge clk);
    wr(ADR, 8'h00);
    rd(ADR, r);
    chk("R7 later clear works", r, 8'h00);

    // R8 R9 sweep latches x enables x mask
    for (int c = 0; c < 32; c++) begin
      logic la, lb, ea, eb, m, xa, xb;
      la = c[0]; lb = c[1]; ea = c[2]; eb = c[3]; m = c[4];
      irq_mask = 1'b0;
      wr(ADR, 8'h00);
      if (la) fall_pin(0);
      if (lb) fall_pin(1);
      wr(ADR, {6'b000011, eb, ea});
      @(negedge clk);
      irq_mask = m;
      #1;
      xa = la & ea & ~m;
      xb = lb & eb & ~m;
      chk("R8 irq_a", {7'h0, irq_a}, {7'h0, xa});
      chk("R8 irq_b", {7'h0, irq_b}, {7'h0, xb});
      chk("R9 irq", {7'h0, irq}, {7'h0, xa | xb});
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule